// File: doc/BRIEF.md
# Four-Beat Wraparound Burst Address Sequencer

This block produces the address for a short burst into a synchronous memory. When an address strobe (already qualified by the chip enables outside this block) captures an external address, the block registers the upper address bits and takes the two low bits as the starting beat. Each later clock with the active-low advance input asserted moves to the next beat. The low bits follow either an interleaved order or a linear order, and they wrap back to the starting beat after four beats.

A static order-select input chooses the sequence. Low selects linear order: the start value plus the beat count, modulo four. High selects interleaved order: the start value XOR the beat count. The output is the registered upper address concatenated with the current two-bit offset. It is valid in the cycle after the capturing or advancing edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and right after it is released, addr_o is all zeros.
- R2: When load_i is high at a rising edge, addr_o after that edge equals addr_i as sampled at that edge.
- R3: When load_i is low and step_n_i is low at a rising edge, the beat count advances by one.
- R4: When load_i is low and step_n_i is high at a rising edge, addr_o does not change, provided mode_i is held.
- R5: With mode_i high (interleaved), the low two bits are the start XOR the beat. Starting at 01, the order is 01,00,11,10. Starting at 10, it is 10,11,00,01. Starting at 11, it is 11,10,01,00.
- R6: With mode_i low (linear), the low two bits are the start plus the beat, modulo 4. For example, starting at 01 the order is 01,10,11,00.
- R7: After four advances the offset is back at the starting value, and further advances repeat the same order.
- R8: When load_i and step_n_i low occur at the same edge, the load wins and the burst restarts at beat 0 of the new address.
- R9: Advances never change the upper address bits addr_o[ADDR_W-1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Qualified address capture strobe |
| step_n_i | input | 1 | Advance to next beat, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench walks every starting value through five advances in both orders. The fifth advance exposes a counter that saturates instead of wrapping, and the per-start tables expose an interleaved order computed as addition. It drives a load in the same edge as an advance: a design with the wrong priority comes out one beat ahead. It also holds advance high for several cycles, and it checks that the upper bits never move during a burst, which catches a carry leaking out of the two-bit field. Random mixes of loads, holds, advances and mode changes are compared against a reference model in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_addr_capture.sv
module burst_addr_capture #(
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 2,
  localparam int UP_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [UP_W-1:0]   upper_o,
  output logic [OFF_W-1:0]  start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o <= '0;
      start_o <= '0;
    end else if (load_i) begin
      upper_o <= addr_i[ADDR_W-1:OFF_W];
      start_o <= addr_i[OFF_W-1:0];
    end
  end

  assert_upper_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(upper_o));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int OFF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [OFF_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clear_i) beat_o <= '0;   // load beats advance
    else if (step_i)  beat_o <= beat_o + 1'b1;  // natural wrap
  end

  assert_beat_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i) |=> beat_o == OFF_W'($past(beat_o) + 1'b1));
  assert_load_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> beat_o == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  order_e           order_i,
  input  logic [OFF_W-1:0] start_i,
  input  logic [OFF_W-1:0] beat_i,
  output logic [OFF_W-1:0] off_o
);
  always_comb begin
    unique case (order_i)
      ORDER_INTERLEAVE: off_o = start_i ^ beat_i;
      default:          off_o = start_i + beat_i;
    endcase
  end

  always_comb begin
    if (beat_i == '0) assert_first_beat_R2: assert (off_o == start_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_n_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - OFF_W;

  logic [UP_W-1:0]  upper_q;
  logic [OFF_W-1:0] start_q;
  logic [OFF_W-1:0] beat_q;
  logic [OFF_W-1:0] off;
  order_e           order;

  assign order = order_e'(mode_i);

  burst_addr_capture #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .addr_i  (addr_i),
    .upper_o (upper_q),
    .start_o (start_q)
  );

  burst_beat_cnt #(.OFF_W(OFF_W)) i_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_i),
    .step_i  (!step_n_i),
    .beat_o  (beat_q)
  );

  burst_order_map #(.OFF_W(OFF_W)) i_map (
    .order_i (order),
    .start_i (start_q),
    .beat_i  (beat_q),
    .off_o   (off)
  );

  assign addr_o = {upper_q, off};

  assert_load_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_n_i) |=> ($stable(addr_o) || !$stable(mode_i)));
  assert_linear_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_n_i && !mode_i) |=>
      (mode_i || addr_o[OFF_W-1:0] == OFF_W'($past(addr_o[OFF_W-1:0]) + 1'b1)));
  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> addr_o == '0);
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic          step_n_i = 1'b1;
  logic          mode_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_beat = '0;

  burst_addr_seq i_burst_addr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_n_i(step_n_i),
    .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [AW-1:0] exp_addr(input logic md);
    logic [1:0] o;
    o = md ? (m_start ^ m_beat) : 2'(m_start + m_beat);
    return {m_up, o};
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string tag);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  task automatic run(input logic ld, input logic stp_n, input logic [AW-1:0] a,
                     input logic md, input string tag);
    @(negedge clk_i);
    load_i = ld; step_n_i = stp_n; addr_i = a; mode_i = md;
    @(posedge clk_i);
    if (ld) begin
      m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
    end else if (!stp_n) m_beat = m_beat + 2'd1;
    #1;
    check(exp_addr(md), tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [1:0] lin_tbl [4];
    logic [1:0] il_tbl [4];
    logic [AW-1:0] base;
    void'($urandom(32'd4242));
    addr_i = 18'h2_5A5F;
    repeat (3) @(posedge clk_i);
    #1 check('0, "R1");
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1 check('0, "R1");

    // directed tables: every start, both orders, five advances (wrap)
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        base = {16'hC3A0 + 16'(s), 2'(s)};
        run(1'b1, 1'b1, base, md[0], "R2");
        for (int k = 1; k <= 5; k++) begin
          run(1'b0, 1'b0, 18'h0, md[0], k == 4 ? "R7" : (md != 0 ? "R5" : "R6"));
          // explicit table cross-check independent of model
          lin_tbl[k%4] = 2'(s + k);
          il_tbl[k%4]  = 2'(s) ^ 2'(k);
          n_chk++;
          if (addr_o[1:0] !== (md != 0 ? il_tbl[k%4] : lin_tbl[k%4]) ||
              addr_o[AW-1:2] !== base[AW-1:2]) begin
            n_bad++;
            $display("FAIL R9 addr_o=%h expected low=%0d up=%h", addr_o,
                     md != 0 ? il_tbl[k%4] : lin_tbl[k%4], base[AW-1:2]);
          end
        end
      end
    end

    // interleaved start 10: fixed order 10,11,00,01
    run(1'b1, 1'b1, 18'h0_0012, 1'b1, "R5");
    run(1'b0, 1'b0, 18'h0, 1'b1, "R5");
    n_chk++;
    if (addr_o[1:0] !== 2'b11) begin
      n_bad++; $display("FAIL R5 low=%b expected=11", addr_o[1:0]);
    end

    // hold for several cycles
    run(1'b0, 1'b0, 18'h0, 1'b0, "R3");
    for (int k = 0; k < 4; k++) run(1'b0, 1'b1, 18'h3_FFFF, 1'b0, "R4");

    // load together with advance
    run(1'b0, 1'b0, 18'h0, 1'b1, "R3");
    run(1'b1, 1'b0, 18'h1_2347, 1'b1, "R8");
    run(1'b0, 1'b0, 18'h0, 1'b1, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic ld, sn, md;
      ld = ($urandom % 5) == 0;
      sn = ($urandom % 3) == 0;
      md = ($urandom % 8) != 0 ? mode_i : ~mode_i;
      run(ld, sn, AW'($urandom), md, ld ? "R2" : (sn ? "R4" : "R3"));
    end
    finish_run();
  end
endmodule